// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block sits between a processor request port and a simple word-wide memory port. It keeps a parameterised number of ways per set. Each way holds a line of several words, with a tag, a valid bit and a dirty bit. Every request reads the selected set and compares all of its tags in the same cycle. A read hit or a write-back store hit completes in that same cycle. A miss stalls the processor while whole lines move between the cache and memory, one word per memory handshake.

Two build-time parameters choose the behaviour. The write policy is either write-back with allocation on a store miss, or write-through with no allocation. The replacement choice is either a round-robin pointer kept for each set, or one pointer shared by every set. Ways that hold no valid line are always used before either pointer is consulted.

Top module: `sa_cache`

## Requirements
- R1: Addresses are byte addresses of word-aligned accesses (the two low bits are zero for 32-bit words). Above those bits come the word-in-line bits, then log2(SETS) set bits, then the tag. A read returns the memory word stored at that address.
- R2: A lookup hits only when a way of the selected set is valid and holds the address tag. A read hit raises cpu_ready in the cycle of the request and causes no memory traffic.
- R3: A miss reads the whole line from memory in LINE_WORDS read beats, words in ascending order. The request then completes as a hit. With a clean or empty victim, cpu_ready rises 2*LINE_WORDS+1 cycles after the request.
- R4: When the selected set has an invalid way, the lowest-numbered invalid way receives the fill and no valid line is evicted.
- R5: In round-robin mode (RANDOM_REPL=0), each set has its own pointer. The pointer names the next victim and advances, modulo WAYS, only when a valid line of that set is evicted.
- R6: In shared mode (RANDOM_REPL=1), a single pointer names the victim for every set. It advances, modulo WAYS, on each eviction of a valid line anywhere.
- R7: In write-back mode, a store hit updates only the cached word, marks the line dirty and completes with no memory write.
- R8: In write-back mode, a dirty victim is written to memory in LINE_WORDS write beats before the fill starts, which gives 4*LINE_WORDS+1 cycles of stall. A clean victim is dropped with no memory write.
- R9: In write-back mode, a store miss first fills the line from memory and then merges the store word into it. Memory is not written.
- R10: In write-through mode, every store writes exactly one word to memory. A store hit also updates the cached word. A store miss leaves the cache unchanged and causes no line read.
- R11: cpu_ready is high only while cpu_req is high, and it stays low throughout every line fill, write-back and memory write.
- R12: Reset clears every valid bit, every dirty bit and every replacement pointer. Lines cached before a reset miss afterwards, and their unwritten dirty data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Request is a store |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Memory word byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the current word |

## Verification
The assertions assume that a processor request, once raised, stays up with the same address and data until cpu_ready. They also assume that every address is word aligned. The one-hot hit check further assumes that no two ways of a set ever hold the same tag, which holds because a fill only happens after a missed lookup. The bench keeps to these assumptions by driving each request from a task that holds all request fields until ready is seen and only then drops the request. Its memory model acknowledges each word one cycle after the request and never while the previous acknowledge is still high.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTHRU = 2'd3
  } cst_e;
endpackage

// File: rtl/sa_cache_tags.sv
module sa_cache_tags #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  input  logic [TAG_W-1:0]      tag,
  input  logic                  commit_en,
  input  logic [WAYS-1:0]       commit_sel,
  input  logic                  mark_en,
  input  logic [WAYS-1:0]       mark_sel,
  output logic [WAYS-1:0]       hit_vec,
  output logic [WAYS-1:0]       valid_o,
  output logic [WAYS-1:0]       dirty_o,
  output logic [WAYS*TAG_W-1:0] tag_flat_o
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (commit_en) begin
      valid_q[idx] <= valid_q[idx] | commit_sel;
      dirty_q[idx] <= dirty_q[idx] & ~commit_sel;
    end else if (mark_en) begin
      dirty_q[idx] <= dirty_q[idx] | mark_sel;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (commit_en && commit_sel[w]) tag_q[idx][w] <= tag;
    end
  end

  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
    assign tag_flat_o[w*TAG_W +: TAG_W] = tag_q[idx][w];
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_o & ~valid_o) == '0); // R7
endmodule

// File: rtl/sa_cache_repl.sv
module sa_cache_repl #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int IDX_W = 2,
  parameter int PTR_W = 1,
  parameter bit RANDOM_REPL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             advance,
  output logic [PTR_W-1:0] victim
);
  logic [PTR_W-1:0] cur_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(WAYS-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    victim = cur_ptr;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!valid_i[w]) victim = PTR_W'(w);
    end
  end

  if (RANDOM_REPL) begin : g_shared
    logic [PTR_W-1:0] gptr_q, gptr_d;
    logic unused_idx;
    assign unused_idx = ^idx;
    assign cur_ptr = gptr_q;
    always_comb gptr_d = advance ? bump(gptr_q) : gptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gptr_q <= '0;
      else        gptr_q <= gptr_d;
    end
    AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(gptr_q)); // R6
  end else begin : g_perset
    logic [PTR_W-1:0] ptr_q [SETS];
    assign cur_ptr = ptr_q[idx];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (advance) begin
        ptr_q[idx] <= bump(ptr_q[idx]);
      end
    end
  end

  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~valid_i)) |-> !valid_i[victim]); // R4
endmodule

// File: rtl/sa_cache_data.sv
module sa_cache_data #(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 2,
  parameter int WORD_B = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic [WAYS-1:0]   wsel,
  input  logic [WORD_B-1:0] wword,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WAYS-1:0]   rsel,
  input  logic [WORD_B-1:0] rword,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] line_q [SETS][WAYS][WORDS];
  logic [DATA_W-1:0] way_word [WAYS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (we && wsel[w]) line_q[idx][w][wword] <= wdata;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign way_word[w] = rsel[w] ? line_q[idx][w][rword] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < WAYS; w++) rdata = rdata | way_word[w];
  end
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit RANDOM_REPL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int BYTE_OFF = $clog2(DATA_W/8);
  localparam int WORD_B   = $clog2(LINE_WORDS);
  localparam int OFF_W    = BYTE_OFF + WORD_B;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int PTR_W    = $clog2(WAYS);
  localparam logic [WORD_B-1:0] LAST = WORD_B'(LINE_WORDS-1);

  cst_e              state_q, state_d;
  logic [WORD_B-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0]  vic_q, vic_d;

  logic [WORD_B-1:0] a_word;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  assign a_word = cpu_addr[OFF_W-1:BYTE_OFF];
  assign a_idx  = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  assign a_tag  = cpu_addr[ADDR_W-1:OFF_W+IDX_W];

  logic [WAYS-1:0]       hit_vec, valid_set, dirty_set, vic_oh;
  logic [WAYS*TAG_W-1:0] tag_flat;
  logic [TAG_W-1:0]      vic_tag;
  logic [PTR_W-1:0]      victim, hit_way;
  logic                  hit, advance, commit_en, mark_en;
  logic                  d_we;
  logic [WAYS-1:0]       d_wsel, d_rsel;
  logic [WORD_B-1:0]     d_wword, d_rword;
  logic [DATA_W-1:0]     d_wdata, line_rd;

  assign hit     = |hit_vec;
  assign vic_oh  = WAYS'(1) << vic_q;
  assign vic_tag = tag_flat[vic_q*TAG_W +: TAG_W];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = PTR_W'(w);
    end
  end

  sa_cache_tags #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(a_idx), .tag(a_tag),
    .commit_en(commit_en), .commit_sel(vic_oh),
    .mark_en(mark_en), .mark_sel(hit_vec),
    .hit_vec(hit_vec), .valid_o(valid_set), .dirty_o(dirty_set), .tag_flat_o(tag_flat)
  );

  sa_cache_repl #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .PTR_W(PTR_W),
                  .RANDOM_REPL(RANDOM_REPL)) u_repl (
    .clk(clk), .rst_n(rst_n), .idx(a_idx), .valid_i(valid_set),
    .advance(advance), .victim(victim)
  );

  sa_cache_data #(.WAYS(WAYS), .SETS(SETS), .WORDS(LINE_WORDS), .IDX_W(IDX_W),
                  .WORD_B(WORD_B), .DATA_W(DATA_W)) u_data (
    .clk(clk), .idx(a_idx), .we(d_we), .wsel(d_wsel), .wword(d_wword),
    .wdata(d_wdata), .rsel(d_rsel), .rword(d_rword), .rdata(line_rd)
  );

  assign cpu_rdata = line_rd;
  assign d_rsel    = (state_q == ST_EVICT) ? vic_oh : hit_vec;
  assign d_rword   = (state_q == ST_EVICT) ? cnt_q : a_word;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    vic_d     = vic_q;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    d_we      = 1'b0;
    d_wsel    = hit_vec;
    d_wword   = a_word;
    d_wdata   = cpu_wdata;
    advance   = 1'b0;
    commit_en = 1'b0;
    mark_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (cpu_we && !WRITE_BACK) begin
            state_d = ST_WTHRU;
          end else if (hit) begin
            cpu_ready = 1'b1;
            d_we      = cpu_we;
            mark_en   = cpu_we;
          end else begin
            vic_d   = victim;
            cnt_d   = '0;
            advance = &valid_set;
            state_d = (valid_set[victim] && dirty_set[victim]) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {vic_tag, a_idx, cnt_q, BYTE_OFF'(0)};
        mem_wdata = line_rd;
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {a_tag, a_idx, cnt_q, BYTE_OFF'(0)};
        d_wsel   = vic_oh;
        d_wword  = cnt_q;
        d_wdata  = mem_rdata;
        if (mem_ack) begin
          d_we  = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            commit_en = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {cpu_addr[ADDR_W-1:BYTE_OFF], BYTE_OFF'(0)};
        mem_wdata = cpu_wdata;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          d_we      = hit;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vic_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vic_q   <= vic_d;
    end
  end

  AST_READY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_ready) |=> (cpu_req && $stable(cpu_addr))); // R11
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[BYTE_OFF-1:0] == '0)); // R1
  AST_WT_NO_LINE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && cpu_req && cpu_we) |-> !(mem_req && !mem_we)); // R10
  AST_WB_STORE_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && cpu_ready && cpu_we) |-> !mem_req); // R7
endmodule

// File: tb/sa_cache_test.sv
module sa_cache_memsim #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_wdata,
  output logic [31:0]       mem_rdata,
  output logic              mem_ack,
  output int                n_rd,
  output int                n_wr
);
  localparam int NW = 1 << (ADDR_W-2);
  logic [31:0]   store [NW];
  logic [NW-1:0] wr_mark = '0;
  logic          ack_q = 1'b0;
  logic [31:0]   rd_q = '0;
  int            cnt_rd = 0;
  int            cnt_wr = 0;

  function automatic logic [31:0] fval(input int a);
    return 32'((a/4)*7 + 256);
  endfunction

  always @(posedge clk) begin
    if (ack_q) begin
      ack_q <= 1'b0;
    end else if (mem_req) begin
      ack_q <= 1'b1;
      if (mem_we) begin
        store[mem_addr[ADDR_W-1:2]]   <= mem_wdata;
        wr_mark[mem_addr[ADDR_W-1:2]] <= 1'b1;
        cnt_wr <= cnt_wr + 1;
      end else begin
        rd_q <= wr_mark[mem_addr[ADDR_W-1:2]] ? store[mem_addr[ADDR_W-1:2]]
                                              : fval(int'(mem_addr));
        cnt_rd <= cnt_rd + 1;
      end
    end
  end

  assign mem_ack   = ack_q;
  assign mem_rdata = rd_q;
  assign n_rd      = cnt_rd;
  assign n_wr      = cnt_wr;
endmodule

module sa_cache_test;
  localparam int AW = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [31:0]   a_wd = '0, b_wd = '0;
  logic [31:0]   a_rd, b_rd, am_rd, bm_rd, am_wd, bm_wd;
  logic          a_rdy, b_rdy, am_req, bm_req, am_we, bm_we, am_ack, bm_ack;
  logic [AW-1:0] am_addr, bm_addr;
  int            a_nrd, a_nwr, b_nrd, b_nwr;

  sa_cache #(.ADDR_W(AW), .WRITE_BACK(1'b1), .RANDOM_REPL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(a_req), .cpu_we(a_we), .cpu_addr(a_addr),
    .cpu_wdata(a_wd), .cpu_rdata(a_rd), .cpu_ready(a_rdy), .mem_req(am_req),
    .mem_we(am_we), .mem_addr(am_addr), .mem_wdata(am_wd), .mem_rdata(am_rd),
    .mem_ack(am_ack));
  sa_cache_memsim #(.ADDR_W(AW)) ma (
    .clk(clk), .mem_req(am_req), .mem_we(am_we), .mem_addr(am_addr),
    .mem_wdata(am_wd), .mem_rdata(am_rd), .mem_ack(am_ack), .n_rd(a_nrd), .n_wr(a_nwr));

  sa_cache #(.ADDR_W(AW), .WRITE_BACK(1'b0), .RANDOM_REPL(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .cpu_req(b_req), .cpu_we(b_we), .cpu_addr(b_addr),
    .cpu_wdata(b_wd), .cpu_rdata(b_rd), .cpu_ready(b_rdy), .mem_req(bm_req),
    .mem_we(bm_we), .mem_addr(bm_addr), .mem_wdata(bm_wd), .mem_rdata(bm_rd),
    .mem_ack(bm_ack));
  sa_cache_memsim #(.ADDR_W(AW)) mb (
    .clk(clk), .mem_req(bm_req), .mem_we(bm_we), .mem_addr(bm_addr),
    .mem_wdata(bm_wd), .mem_rdata(bm_rd), .mem_ack(bm_ack), .n_rd(b_nrd), .n_wr(b_nwr));

  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic [31:0] fval(input int a);
    return 32'((a/4)*7 + 256);
  endfunction
  function automatic int line(input int t, input int s);
    return (t << 6) | (s << 4);
  endfunction
  function automatic logic [31:0] peek_a(input int a);
    return ma.wr_mark[a/4] ? ma.store[a/4] : fval(a);
  endfunction
  function automatic logic [31:0] peek_b(input int a);
    return mb.wr_mark[a/4] ? mb.store[a/4] : fval(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit b, input bit we, input int addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    if (b) begin b_req = 1; b_we = we; b_addr = AW'(addr); b_wd = wd; end
    else   begin a_req = 1; a_we = we; a_addr = AW'(addr); a_wd = wd; end
    #1;
    waits = 0;
    while (!(b ? b_rdy : a_rdy) && waits < 1000) begin
      @(negedge clk);
      waits++;
    end
    rd = b ? b_rd : a_rd;
    @(negedge clk);
    if (b) begin b_req = 0; b_we = 0; end
    else   begin a_req = 0; a_we = 0; end
  endtask

  // read with expected data and expected number of line-read beats
  task automatic rd_chk(input bit b, input int addr, input logic [31:0] exp,
                        input int exp_beats, input string rq);
    int r0, w0, waits;
    logic [31:0] rd;
    r0 = b ? b_nrd : a_nrd;
    access(b, 1'b0, addr, '0, rd, waits);
    chk(rd == exp, rq, "read data", rd, exp);
    chk(((b ? b_nrd : a_nrd) - r0) == exp_beats, rq, "read beats",
        (b ? b_nrd : a_nrd) - r0, exp_beats);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int waits, r0, w0;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(a_rdy == 0 && am_req == 0, "R12", "A idle after reset", {a_rdy, am_req}, 0);
    chk(b_rdy == 0 && bm_req == 0, "R12", "B idle after reset", {b_rdy, bm_req}, 0);

    // R1 R2 R3 sweep: every word of eight lines filling all sets and ways
    r0 = a_nrd;
    for (int s = 0; s < 4; s++)
      for (int t = 8; t < 10; t++)
        for (int w = 0; w < 4; w++) begin
          access(0, 0, line(t, s) | (w << 2), '0, rd, waits);
          chk(rd == fval(line(t, s) | (w << 2)), "R1", "sweep data", rd, fval(line(t, s) | (w << 2)));
          chk(waits == ((w == 0) ? 9 : 0), (w == 0) ? "R3" : "R2", "latency", waits, (w == 0) ? 9 : 0);
        end
    chk(a_nrd - r0 == 32, "R3", "sweep fill beats", a_nrd - r0, 32);
    r0 = a_nrd;
    for (int s = 0; s < 4; s++)
      for (int t = 8; t < 10; t++)
        for (int w = 0; w < 4; w++) begin
          access(0, 0, line(t, s) | (w << 2), '0, rd, waits);
          chk(rd == fval(line(t, s) | (w << 2)), "R2", "reread data", rd, fval(line(t, s) | (w << 2)));
        end
    chk(a_nrd - r0 == 0, "R2", "reread causes no traffic", a_nrd - r0, 0);

    // R12: lines cached before reset miss afterwards
    do_reset();
    rd_chk(0, line(8, 0), fval(line(8, 0)), 4, "R12");

    // R4 R5 per-set round robin, set 0 then set 1
    do_reset();
    rd_chk(0, line(0, 0), fval(line(0, 0)), 4, "R4");
    rd_chk(0, line(1, 0), fval(line(1, 0)), 4, "R4");
    rd_chk(0, line(0, 0), fval(line(0, 0)), 0, "R4");
    rd_chk(0, line(2, 0), fval(line(2, 0)), 4, "R5");
    rd_chk(0, line(1, 0), fval(line(1, 0)), 0, "R5");
    rd_chk(0, line(0, 0), fval(line(0, 0)), 4, "R5");
    rd_chk(0, line(2, 0), fval(line(2, 0)), 0, "R5");
    rd_chk(0, line(1, 0), fval(line(1, 0)), 4, "R5");
    rd_chk(0, line(0, 1), fval(line(0, 1)), 4, "R5");
    rd_chk(0, line(1, 1), fval(line(1, 1)), 4, "R5");
    rd_chk(0, line(2, 1), fval(line(2, 1)), 4, "R5");
    rd_chk(0, line(1, 1), fval(line(1, 1)), 0, "R5");
    rd_chk(0, line(0, 1), fval(line(0, 1)), 4, "R5");

    // R6 shared pointer in instance B
    rd_chk(1, line(0, 0), fval(line(0, 0)), 4, "R6");
    rd_chk(1, line(1, 0), fval(line(1, 0)), 4, "R6");
    rd_chk(1, line(2, 0), fval(line(2, 0)), 4, "R6");
    rd_chk(1, line(0, 1), fval(line(0, 1)), 4, "R6");
    rd_chk(1, line(1, 1), fval(line(1, 1)), 4, "R6");
    rd_chk(1, line(2, 1), fval(line(2, 1)), 4, "R6");
    rd_chk(1, line(0, 1), fval(line(0, 1)), 0, "R6");
    rd_chk(1, line(1, 1), fval(line(1, 1)), 4, "R6");

    // R9 R7 R8 write-back behaviour in instance A
    do_reset();
    r0 = a_nrd; w0 = a_nwr;
    access(0, 1, line(3, 2) | 4, 32'hDEAD0001, rd, waits);
    chk(a_nrd - r0 == 4, "R9", "store miss fills line", a_nrd - r0, 4);
    chk(a_nwr - w0 == 0, "R9", "store miss writes no memory", a_nwr - w0, 0);
    chk(waits == 9, "R9", "store miss latency", waits, 9);
    chk(peek_a(line(3, 2) | 4) == fval(line(3, 2) | 4), "R9", "memory untouched",
        peek_a(line(3, 2) | 4), fval(line(3, 2) | 4));
    rd_chk(0, line(3, 2) | 4, 32'hDEAD0001, 0, "R9");
    rd_chk(0, line(3, 2) | 8, fval(line(3, 2) | 8), 0, "R9");
    w0 = a_nwr;
    access(0, 1, line(3, 2) | 4, 32'hDEAD0002, rd, waits);
    chk(a_nwr - w0 == 0 && waits == 0, "R7", "store hit is local", a_nwr - w0, 0);
    chk(peek_a(line(3, 2) | 4) == fval(line(3, 2) | 4), "R7", "memory stale after hit",
        peek_a(line(3, 2) | 4), fval(line(3, 2) | 4));
    rd_chk(0, line(4, 2), fval(line(4, 2)), 4, "R8");
    r0 = a_nrd; w0 = a_nwr;
    access(0, 0, line(5, 2), '0, rd, waits);
    chk(a_nwr - w0 == 4, "R8", "dirty victim write beats", a_nwr - w0, 4);
    chk(a_nrd - r0 == 4, "R8", "fill after write-back", a_nrd - r0, 4);
    chk(waits == 17, "R8", "dirty miss latency", waits, 17);
    chk(rd == fval(line(5, 2)), "R8", "data after eviction", rd, fval(line(5, 2)));
    chk(peek_a(line(3, 2) | 4) == 32'hDEAD0002, "R8", "dirty word reached memory",
        peek_a(line(3, 2) | 4), 32'hDEAD0002);
    chk(peek_a(line(3, 2) | 12) == fval(line(3, 2) | 12), "R8", "other words intact",
        peek_a(line(3, 2) | 12), fval(line(3, 2) | 12));
    w0 = a_nwr;
    rd_chk(0, line(6, 2), fval(line(6, 2)), 4, "R8");
    chk(a_nwr - w0 == 0, "R8", "clean victim dropped", a_nwr - w0, 0);

    // R12: dirty data lost over reset
    access(0, 1, line(7, 1), 32'h0000BEEF, rd, waits);
    do_reset();
    w0 = a_nwr;
    rd_chk(0, line(7, 1), fval(line(7, 1)), 4, "R12");
    chk(a_nwr - w0 == 0, "R12", "no write-back after reset", a_nwr - w0, 0);

    // R10 write-through in instance B
    r0 = b_nrd; w0 = b_nwr;
    access(1, 1, line(20, 3) | 8, 32'h00005A5A, rd, waits);
    chk(b_nwr - w0 == 1, "R10", "store miss writes one word", b_nwr - w0, 1);
    chk(b_nrd - r0 == 0, "R10", "store miss no allocate", b_nrd - r0, 0);
    chk(peek_b(line(20, 3) | 8) == 32'h00005A5A, "R10", "memory updated",
        peek_b(line(20, 3) | 8), 32'h00005A5A);
    rd_chk(1, line(20, 3) | 8, 32'h00005A5A, 4, "R10");
    r0 = b_nrd; w0 = b_nwr;
    access(1, 1, line(20, 3) | 8, 32'h0000A5A5, rd, waits);
    chk(b_nwr - w0 == 1 && b_nrd - r0 == 0, "R10", "store hit writes one word", b_nwr - w0, 1);
    chk(peek_b(line(20, 3) | 8) == 32'h0000A5A5, "R10", "memory updated on hit",
        peek_b(line(20, 3) | 8), 32'h0000A5A5);
    rd_chk(1, line(20, 3) | 8, 32'h0000A5A5, 0, "R10");

    // R11: no ready without request
    @(negedge clk);
    chk(a_rdy == 0 && b_rdy == 0, "R11", "ready low when idle", {a_rdy, b_rdy}, 0);

    done = 1;
    report();
  end
endmodule